// File: doc/BRIEF.md
# Memory-Mapped GPIO Port with Edge Interrupts

This block is a 32-line general-purpose I/O port on a simple 32-bit register bus. Software sets each line as input or output, can make an output drive low only (wired-AND style), and reads back a data word. For a line set as an output, that word holds the latched output value. For an input line, it holds the synchronised pad level, and only if that line's input buffer is enabled. Every register numbers its lines in reverse: line 0 is the most significant bit.

Each pad input passes through a two-flop synchroniser. An edge detector then sets a per-line pending event bit. A control bit picks whether a line reacts to falling edges only or to both edges. Pending bits are cleared by writing ones to them. One interrupt output is high while any pending line is also enabled in the mask register. Reads and writes are word-aligned and acknowledged in the cycle they are presented.

Top module: `pinbank_gpio`

## Requirements
- R1: After a synchronous active-high reset, every register reads 0, `pad_oe` is all zeros and `irq` is low.
- R2: Registers sit at byte offsets direction 0x00, drive-low-only 0x04, data 0x08, pending event 0x0C, interrupt mask 0x10, edge select 0x14 and input enable 0x18. Other offsets read 0. Line n is register bit 31-n and pad port bit n. `bus_ack` equals `bus_sel` in the same cycle, and read data is valid in that cycle.
- R3: A direction bit of 1 makes the line an output. Its `pad_oe` is then high and `pad_out` follows its data bit. A 0 makes it an input, with `pad_oe` low.
- R4: With the drive-low-only bit set on an output line, a data bit of 0 gives `pad_oe`=1 and `pad_out`=0. A data bit of 1 gives `pad_oe`=0, so the line is never driven high.
- R5: A data read returns the output latch for output lines. For input lines it returns the pad level two clocks after the pad changes, if the input enable bit is 1, and 0 otherwise.
- R6: An edge select bit of 0 detects both edges and a 1 detects falling edges only. The event bit sets at the clock after the synchronised value changes, which is the third rising clock edge after the pad changes. No other cause sets an event bit.
- R7: Writing 1 to a pending event bit clears it. Writing 0 leaves it unchanged.
- R8: When an edge is detected on a line in the same cycle that its event bit is written with 1, the bit stays set.
- R9: `irq` is high exactly when some line has both its event bit and its mask bit at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, 0 when not selected |
| bus_ack | output | 1 | Access acknowledge |
| pad_in | input | 32 | Pad levels, bit n = line n |
| pad_out | output | 32 | Output value, bit n = line n |
| pad_oe | output | 32 | Output enable, bit n = line n |
| irq | output | 1 | Combined interrupt |

## Verification
A wrong configuration bit appears on `pad_oe` or `pad_out` at the next falling clock edge, and on the read data whenever that register is addressed. A fault in the synchroniser or edge logic first appears as a pending bit that sets a cycle early or late, sets on the wrong edge polarity, or fails to set. The bench checks the pending register and `irq` on every cycle, so such a fault is caught within one cycle of the edge. Clear-versus-edge collisions are set up on the exact detection cycle, because a wrong priority shows only there.

// File: rtl/pinbank_pkg.sv
`timescale 1ns/1ps
package pinbank_pkg;

    localparam int ADDR_W = 8;

    // Register offsets (bytes)
    localparam logic [7:0] OFS_DIR = 8'h00;
    localparam logic [7:0] OFS_ODN = 8'h04;
    localparam logic [7:0] OFS_DAT = 8'h08;
    localparam logic [7:0] OFS_EVT = 8'h0C;
    localparam logic [7:0] OFS_MSK = 8'h10;
    localparam logic [7:0] OFS_CTL = 8'h14;
    localparam logic [7:0] OFS_IBE = 8'h18;

    typedef enum logic [2:0] {
        SEL_DIR,
        SEL_ODN,
        SEL_DAT,
        SEL_EVT,
        SEL_MSK,
        SEL_CTL,
        SEL_IBE,
        SEL_NONE
    } reg_sel_e;

    // Per-line configuration, kept in line order
    typedef struct packed {
        logic dir;   // 1 = output
        logic odn;   // drive-low-only
        logic dat;   // output latch
        logic msk;   // interrupt enable
        logic ctl;   // 1 = falling only
        logic ibe;   // input buffer enable
    } pin_cfg_t;

    function automatic logic edge_hit(logic prev, logic cur, logic fall_only);
        return fall_only ? (prev & ~cur) : (prev ^ cur);
    endfunction

    function automatic pin_cfg_t pin_write(pin_cfg_t c, reg_sel_e s, logic b);
        pin_cfg_t n;
        n = c;
        case (s)
            SEL_DIR: n.dir = b;
            SEL_ODN: n.odn = b;
            SEL_DAT: n.dat = b;
            SEL_MSK: n.msk = b;
            SEL_CTL: n.ctl = b;
            SEL_IBE: n.ibe = b;
            default: n = c;
        endcase
        return n;
    endfunction

    function automatic logic pin_read(reg_sel_e s, pin_cfg_t c, logic ev, logic smp);
        logic r;
        case (s)
            SEL_DIR: r = c.dir;
            SEL_ODN: r = c.odn;
            SEL_DAT: r = c.dir ? c.dat : (c.ibe & smp);
            SEL_EVT: r = ev;
            SEL_MSK: r = c.msk;
            SEL_CTL: r = c.ctl;
            SEL_IBE: r = c.ibe;
            default: r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pinbank_sync.sv
`timescale 1ns/1ps
module pinbank_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '0;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/pinbank_event.sv
`timescale 1ns/1ps
module pinbank_event #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] sync_in,
    input  logic [NPINS-1:0] fall_only,
    input  logic [NPINS-1:0] clr,
    output logic [NPINS-1:0] hit,
    output logic [NPINS-1:0] evt
);

    logic [NPINS-1:0] prev;

    for (genvar p = 0; p < NPINS; p++) begin : g_det
        assign hit[p] = pinbank_pkg::edge_hit(prev[p], sync_in[p], fall_only[p]);
    end

    // A detected edge outranks a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= '0;
            evt  <= '0;
        end else begin
            prev <= sync_in;
            evt  <= (evt & ~clr) | hit;
        end
    end

endmodule

// File: rtl/pinbank_gpio.sv
`timescale 1ns/1ps
module pinbank_gpio
    import pinbank_pkg::*;
#(
    parameter int NPINS   = 32,
    parameter int AW      = ADDR_W,
    parameter int SYNC_FF = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [AW-1:0]    bus_addr,
    input  logic [NPINS-1:0] bus_wdata,
    output logic [NPINS-1:0] bus_rdata,
    output logic             bus_ack,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe,
    output logic             irq
);

    reg_sel_e         sel;
    logic             wr_en;
    pin_cfg_t         cfg [NPINS];
    logic [NPINS-1:0] wr_pin;
    logic [NPINS-1:0] rd_pin;
    logic [NPINS-1:0] sync_vec;
    logic [NPINS-1:0] clr_vec;
    logic [NPINS-1:0] hit_vec;
    logic [NPINS-1:0] evt_vec;
    logic [NPINS-1:0] msk_vec;
    logic [NPINS-1:0] ctl_vec;

    always_comb begin
        case (bus_addr)
            AW'(OFS_DIR): sel = SEL_DIR;
            AW'(OFS_ODN): sel = SEL_ODN;
            AW'(OFS_DAT): sel = SEL_DAT;
            AW'(OFS_EVT): sel = SEL_EVT;
            AW'(OFS_MSK): sel = SEL_MSK;
            AW'(OFS_CTL): sel = SEL_CTL;
            AW'(OFS_IBE): sel = SEL_IBE;
            default:      sel = SEL_NONE;
        endcase
    end

    assign wr_en   = bus_sel & bus_wr;
    assign bus_ack = bus_sel;

    pinbank_sync #(.W(NPINS), .STAGES(SYNC_FF)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (sync_vec)
    );

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        // Line p lives at register bit NPINS-1-p
        assign wr_pin[p] = bus_wdata[NPINS-1-p];

        always_ff @(posedge clk) begin
            if (rst)        cfg[p] <= '0;
            else if (wr_en) cfg[p] <= pin_write(cfg[p], sel, wr_pin[p]);
        end

        assign clr_vec[p] = wr_en & (sel == SEL_EVT) & wr_pin[p];
        assign msk_vec[p] = cfg[p].msk;
        assign ctl_vec[p] = cfg[p].ctl;

        assign pad_oe[p]  = cfg[p].dir & ~(cfg[p].odn & cfg[p].dat);
        assign pad_out[p] = cfg[p].dat & ~cfg[p].odn;

        assign rd_pin[p]  = pin_read(sel, cfg[p], evt_vec[p], sync_vec[p]);
        assign bus_rdata[NPINS-1-p] = bus_sel & rd_pin[p];
    end

    pinbank_event #(.NPINS(NPINS)) u_event (
        .clk       (clk),
        .rst       (rst),
        .sync_in   (sync_vec),
        .fall_only (ctl_vec),
        .clr       (clr_vec),
        .hit       (hit_vec),
        .evt       (evt_vec)
    );

    assign irq = |(evt_vec & msk_vec);

endmodule

// File: rtl/pinbank_gpio_chk.sv
`timescale 1ns/1ps
module pinbank_gpio_chk #(
    parameter int NPINS = 32
) (
    input logic             clk,
    input logic             rst,
    input logic [NPINS-1:0] clr,
    input logic [NPINS-1:0] hit,
    input logic [NPINS-1:0] evt,
    input logic [NPINS-1:0] pad_oe
);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (evt == '0 && pad_oe == '0));

    // R7
    w1c_clears_chk: assert property (@(posedge clk) disable iff (rst)
        ((clr & ~hit) != '0) |=> ((evt & $past(clr & ~hit)) == '0));

    // R8
    edge_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (hit != '0) |=> ((evt & $past(hit)) == $past(hit)));

    // R6
    evt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (hit == '0 && clr == '0) |=> $stable(evt));

    // R6
    evt_cause_chk: assert property (@(posedge clk) disable iff (rst)
        ((evt & ~$past(evt) & ~$past(hit)) == '0));

endmodule

bind pinbank_gpio pinbank_gpio_chk #(.NPINS(NPINS)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr_vec),
    .hit    (hit_vec),
    .evt    (evt_vec),
    .pad_oe (pad_oe)
);

// File: tb/pinbank_gpio_test.sv
`timescale 1ns/1ps
module pinbank_gpio_test;

    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst;
    logic         bus_sel, bus_wr;
    logic [7:0]   bus_addr;
    logic [N-1:0] bus_wdata, bus_rdata;
    logic         bus_ack;
    logic [N-1:0] pad_in, pad_out, pad_oe;
    logic         irq;

    int checks = 0;
    int errors = 0;
    int wd     = 0;
    bit cmp_en = 1'b0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pinbank_gpio uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .irq(irq)
    );

    // Behavioural reference state, indexed by line number
    logic [N-1:0] m_dir, m_od, m_dat, m_msk, m_ctl, m_ibe, m_evt;
    logic [N-1:0] m_s1, m_s2, m_s3;

    function automatic logic [N-1:0] flip(logic [N-1:0] v);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) r[i] = v[N-1-i];
        return r;
    endfunction

    function automatic logic [N-1:0] m_read(logic [7:0] a);
        logic [N-1:0] pv;
        for (int i = 0; i < N; i++) pv[i] = m_dir[i] ? m_dat[i] : (m_ibe[i] & m_s2[i]);
        case (a)
            8'h00:   return flip(m_dir);
            8'h04:   return flip(m_od);
            8'h08:   return flip(pv);
            8'h0C:   return flip(m_evt);
            8'h10:   return flip(m_msk);
            8'h14:   return flip(m_ctl);
            8'h18:   return flip(m_ibe);
            default: return '0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin : model_b
        logic [N-1:0] hit, wv, clr;
        if (rst) begin
            m_dir = '0; m_od = '0; m_dat = '0; m_msk = '0; m_ctl = '0;
            m_ibe = '0; m_evt = '0; m_s1 = '0; m_s2 = '0; m_s3 = '0;
        end else begin
            for (int i = 0; i < N; i++)
                hit[i] = (m_s2[i] != m_s3[i]) && (!m_ctl[i] || !m_s2[i]);
            wv  = flip(bus_wdata);
            clr = '0;
            if (bus_sel && bus_wr) begin
                case (bus_addr)
                    8'h00: m_dir = wv;
                    8'h04: m_od  = wv;
                    8'h08: m_dat = wv;
                    8'h0C: clr   = wv;
                    8'h10: m_msk = wv;
                    8'h14: m_ctl = wv;
                    8'h18: m_ibe = wv;
                    default: ;
                endcase
            end
            m_evt = (m_evt & ~clr) | hit;
            m_s3 = m_s2;
            m_s2 = m_s1;
            m_s1 = pad_in;
        end
    end

    always @(negedge clk) begin : cmp_b
        logic [N-1:0] e_oe, e_out;
        string tag;
        if (cmp_en) begin
            for (int i = 0; i < N; i++) begin
                e_oe[i]  = m_dir[i] & ~(m_od[i] & m_dat[i]);
                e_out[i] = m_dat[i] & ~m_od[i];
            end
            check("R3 pad_oe", pad_oe, e_oe);
            check("R4 pad_out", pad_out, e_out);
            check("R9 irq", {31'b0, irq}, {31'b0, |(m_evt & m_msk)});
            check("R2 ack", {31'b0, bus_ack}, {31'b0, bus_sel});
            case (bus_addr)
                8'h08:   tag = "R5 data read";
                8'h0C:   tag = "R6 event read";
                default: tag = "R2 register read";
            endcase
            check(tag, bus_rdata, bus_sel ? m_read(bus_addr) : '0);
        end
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 20000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic wr(input logic [7:0] a, input logic [N-1:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [N-1:0] exp, input string tag);
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        check(tag, bus_rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(posedge clk); #1;
            bus_wr = 1'b0;
            bus_addr = (bus_addr + 8'd4) & 8'h1C;
        end
    endtask

    task automatic set_pad(input logic [N-1:0] v);
        @(posedge clk); #1;
        pad_in = v;
    endtask

    initial begin
        rst = 1'b1; bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'h00;
        bus_wdata = '0; pad_in = '0;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        cmp_en = 1'b1;

        // R1: reset values
        for (int a = 0; a <= 8'h1C; a += 4)
            rd_chk(8'(a), '0, "R1 reset readback");
        @(negedge clk);
        check("R1 reset pad_oe", pad_oe, '0);
        check("R1 reset irq", {31'b0, irq}, '0);

        // R2 / R3: line 0 at the most significant register bit
        wr(8'h00, 32'h8000_0000);
        wr(8'h08, 32'h8000_0000);
        @(negedge clk);
        check("R2 line0 oe", pad_oe, 32'h0000_0001);
        check("R3 line0 drives data", pad_out, 32'h0000_0001);
        rd_chk(8'h08, 32'h8000_0000, "R5 output latch readback");

        // R4: drive-low-only on line 5 (bit 26)
        wr(8'h00, 32'h8400_0000);
        wr(8'h04, 32'h0400_0000);
        @(negedge clk);
        check("R4 od low oe", pad_oe, 32'h0000_0021);
        check("R4 od low out", pad_out, 32'h0000_0001);
        wr(8'h08, 32'h8400_0000);
        @(negedge clk);
        check("R4 od release oe", pad_oe, 32'h0000_0001);
        check("R4 od release out", pad_out, 32'h0000_0001);

        // R5 / R6: line 10 (bit 21) rises
        set_pad(32'h0000_0400);
        idle(4);
        rd_chk(8'h08, 32'h8400_0000, "R5 input gated off");
        wr(8'h18, 32'h0020_0000);
        rd_chk(8'h08, 32'h8420_0000, "R5 input gated on");
        rd_chk(8'h0C, 32'h0020_0000, "R6 rise seen in both-edge mode");
        @(negedge clk);
        check("R9 masked no irq", {31'b0, irq}, '0);
        wr(8'h10, 32'h0020_0000);
        @(negedge clk);
        check("R9 unmasked irq", {31'b0, irq}, 32'h1);

        // R7: zero write keeps, one write clears
        wr(8'h0C, 32'h0000_0000);
        rd_chk(8'h0C, 32'h0020_0000, "R7 zero write keeps");
        wr(8'h0C, 32'h0020_0000);
        rd_chk(8'h0C, 32'h0000_0000, "R7 one write clears");
        @(negedge clk);
        check("R9 irq drops after clear", {31'b0, irq}, '0);

        // R6: falling-only on line 7 (bit 24)
        wr(8'h14, 32'h0100_0000);
        set_pad(32'h0000_0480);
        idle(4);
        rd_chk(8'h0C, 32'h0000_0000, "R6 rise ignored falling-only");
        set_pad(32'h0000_0400);
        idle(4);
        rd_chk(8'h0C, 32'h0100_0000, "R6 fall detected");
        wr(8'h0C, 32'h0100_0000);

        // R8: clear lands on the detection cycle of line 12 (bit 19)
        set_pad(32'h0000_1400);
        @(posedge clk);
        wr(8'h0C, 32'h0008_0000);
        rd_chk(8'h0C, 32'h0008_0000, "R8 edge beats clear");
        wr(8'h0C, 32'h0008_0000);
        rd_chk(8'h0C, 32'h0000_0000, "R8 later clear works");

        // Mixed traffic against the reference model
        for (int k = 0; k < 400; k++) begin
            @(posedge clk); #1;
            bus_addr = 8'(($urandom % 8) * 4);
            if ($urandom % 4 == 0) begin
                bus_wr = 1'b1;
                bus_wdata = $urandom;
            end else begin
                bus_wr = 1'b0;
            end
            if ($urandom % 3 == 0)
                pad_in = pad_in ^ (32'h1 << ($urandom % 32));
        end
        @(posedge clk); #1;
        bus_wr = 1'b0;
        idle(4);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule